// File: doc/BRIEF.md
# Codec Powerdown and Clock-Loss Controller

This block gathers every condition that must power down a voice codec and turns it into one powerdown state. That state tri-states the serial data output, and for the reset-type causes it also forces the control registers. Four causes are handled:

- a hold-off that follows reset;
- the bit clock stopping in its high state;
- the powerdown code in the two mode bits of control register A;
- the serial control line held high while the control address is at its lowest level.

Two of these causes are reset-type: the hold-off and clock loss. They drive strobes that load register A with its powerdown value, clear register B and block writes to both registers. The other two causes leave the registers alone. With those two, the system-drive outputs keep their values and register B can still be written.

Clock loss is found from a free-running reference clock. A divided copy of the bit clock is handed to the reference domain. If no toggle of that copy arrives for a parameterised number of reference cycles, clock loss is declared. The default limit is set so the declaration lands 10 to 40 µs after the clock stops. A clock loss resets the hold-off timer, so the full hold-off runs again once bit-clock edges return.

Top module: `codec_pd_ctrl`

## Requirements
- R1: While rst_ni is low, pd_o, dout_hiz_o, reg_a_force_o and reg_b_clr_o are all 1.
- R2: After rst_ni rises, reg_a_force_o and reg_b_clr_o stay 1 through bit-clock rising edge HOLD_CYCLES+2 and go low after it. The 2 extra edges come from the reset synchronizer. With no other cause active, pd_o stays 1 through edge HOLD_CYCLES+3 and then goes low.
- R3: If bit_clk_i stays high, pd_o, dout_hiz_o, reg_a_force_o and reg_b_clr_o are all 1 no sooner than 10 µs and no later than 40 µs after the clock stopped.
- R4: When the bit clock resumes after a loss, pd_o stays 1 without a break while the register strobes are high. pd_o falls one bit-clock edge after the strobes fall, and the strobes fall no earlier than edge HOLD_CYCLES+2 after the restart.
- R5: A value of 2'b11 on a_mode_i (register A bits 7..6) sampled at a rising edge makes pd_o 1 after that edge. pd_o returns to 0 after the first edge that samples another value.
- R6: The a_mode_i values 2'b00 (normal), 2'b01 (digital loopback) and 2'b10 (analog loopback) never raise pd_o.
- R7: The static-high condition is ctl_line_i = 1 with ca_level_i = 2'b00, the lowest level. Rising edge k of a run of that condition leaves pd_o at 1 when k ≥ STATIC_CYCLES+1, and at 0 otherwise. pd_o clears after the second edge that samples the condition false.
- R8: A run of the static-high condition shorter than STATIC_CYCLES edges does not raise pd_o. ctl_line_i held high at ca_level_i 2'b01, 2'b10 or 2'b11 never raises pd_o.
- R9: Powerdown caused by register A or by the static-high line keeps reg_a_force_o and reg_b_clr_o at 0.
- R10: dout_hiz_o equals pd_o at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Serial bit clock; all control inputs are sampled on its rising edge |
| ref_clk_i | input | 1 | Free-running reference clock for clock-loss timing |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_mode_i | input | 2 | Register A bits 7..6 (00 normal, 01 digital loop, 10 analog loop, 11 powerdown) |
| ca_level_i | input | 2 | Control address level (00 lowest, 01 middle, 10 and 11 highest) |
| ctl_line_i | input | 1 | Level of the serial control line |
| pd_o | output | 1 | Combined powerdown state |
| dout_hiz_o | output | 1 | Forces the serial data output to high impedance |
| reg_a_force_o | output | 1 | Loads register A with 11_000000 and blocks writes to it |
| reg_b_clr_o | output | 1 | Clears register B and blocks writes to it |

## Verification
- **Register A and the static-high line:** these causes act through a single register, so pd_o follows a sampled mode code after one bit-clock edge. For the static-high line, pd_o follows on edge STATIC_CYCLES+1 of a run and clears two edges after the line drops.
- **After reset:** the strobes fall HOLD_CYCLES+2 edges after reset release, and pd_o falls one edge later.
- **How the bench samples:** it drives inputs and samples outputs at the falling edge. It therefore counts rising edges exactly and compares against these latencies on every edge of each run length it sweeps.
- **Clock loss:** because it is measured against the unrelated reference clock, it is checked as a time window rather than a cycle. The restart is checked as a continuous-high condition followed by the one-edge offset between strobe and flag.

// File: rtl/codec_pd_pkg.sv
`timescale 1ns/1ps
package codec_pd_pkg;
  typedef enum logic [1:0] {
    CA_LOW    = 2'b00,
    CA_MID    = 2'b01,
    CA_HIGH   = 2'b10,
    CA_HIGH_B = 2'b11
  } ca_level_e;

  typedef enum logic [1:0] {
    AM_NORMAL = 2'b00,
    AM_DLOOP  = 2'b01,
    AM_ALOOP  = 2'b10,
    AM_PWRDN  = 2'b11
  } a_mode_e;
endpackage

// File: rtl/codec_pd_rst_sync.sv
`timescale 1ns/1ps
module codec_pd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) sync_q <= '0;
      else          sync_q <= 1'b1;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) sync_q <= '0;
      else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/codec_pd_loss_det.sv
`timescale 1ns/1ps
module codec_pd_loss_det #(
  parameter int unsigned DIV_LOG2    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOSS_LIMIT  = 25
) (
  input  logic bit_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic loss_o
);
  localparam int unsigned CW = $clog2(LOSS_LIMIT + 1);
  localparam logic [CW-1:0] LIM   = CW'(LOSS_LIMIT);
  localparam logic [CW-1:0] LIM_M = CW'(LOSS_LIMIT - 1);

  // slow toggle so the reference domain never aliases the bit clock
  logic [DIV_LOG2-1:0] div_q;
  logic                tog_q;
  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      tog_q <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      if (&div_q) tog_q <= ~tog_q;
    end
  end

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [CW-1:0]          cnt_q;
  logic                   loss_q;
  logic                   seen;

  assign seen = sync_q[SYNC_STAGES-1] ^ last_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
      cnt_q  <= '0;
      loss_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tog_q};
      last_q <= sync_q[SYNC_STAGES-1];
      if (seen)              cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      loss_q <= !seen && (cnt_q >= LIM_M);
    end
  end

  assign loss_o = loss_q;
endmodule

// File: rtl/codec_pd_hold.sv
`timescale 1ns/1ps
module codec_pd_hold #(
  parameter int unsigned HOLD_CYCLES = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic hold_o
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HMAX = HW'(HOLD_CYCLES);

  logic [HW-1:0] cnt_q;
  logic [HW-1:0] cnt_d;
  logic          hold_q;

  assign cnt_d = (cnt_q == HMAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= (cnt_d != HMAX);
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/codec_pd_static_det.sv
`timescale 1ns/1ps
module codec_pd_static_det
  import codec_pd_pkg::*;
#(
  parameter int unsigned STATIC_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ca_level_i,
  input  logic       ctl_line_i,
  output logic       static_o
);
  localparam int unsigned SW = $clog2(STATIC_CYCLES + 1);
  localparam logic [SW-1:0] SMAX   = SW'(STATIC_CYCLES);
  localparam logic [SW-1:0] SMAX_M = SW'(STATIC_CYCLES - 1);

  logic [SW-1:0] cnt_q;
  logic          static_q;
  logic          cond;

  assign cond = (ca_level_i == CA_LOW) && ctl_line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      static_q <= 1'b0;
    end else begin
      if (!cond)              cnt_q <= '0;
      else if (cnt_q != SMAX) cnt_q <= cnt_q + 1'b1;
      static_q <= cond && (cnt_q >= SMAX_M);
    end
  end

  assign static_o = static_q;
endmodule

// File: rtl/codec_pd_ctrl.sv
`timescale 1ns/1ps
module codec_pd_ctrl
  import codec_pd_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES   = 25,
  parameter int unsigned STATIC_CYCLES = 16,
  parameter int unsigned DIV_LOG2      = 2,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned REF_PERIOD_NS = 1000,
  parameter int unsigned LOSS_MIN_NS   = 10000,
  parameter int unsigned LOSS_MAX_NS   = 40000
) (
  input  logic       bit_clk_i,
  input  logic       ref_clk_i,
  input  logic       rst_ni,
  input  logic [1:0] a_mode_i,
  input  logic [1:0] ca_level_i,
  input  logic       ctl_line_i,
  output logic       pd_o,
  output logic       dout_hiz_o,
  output logic       reg_a_force_o,
  output logic       reg_b_clr_o
);
  // aim at the middle of the allowed window; toggle gap and sync add margin
  localparam int unsigned LOSS_LIMIT = (LOSS_MIN_NS + LOSS_MAX_NS) / (2 * REF_PERIOD_NS);

  logic loss;
  logic hold_arst_n;
  logic core_rst_n;
  logic hold;
  logic static_hi;
  logic pd_q;

  codec_pd_loss_det #(
    .DIV_LOG2   (DIV_LOG2),
    .SYNC_STAGES(SYNC_STAGES),
    .LOSS_LIMIT (LOSS_LIMIT)
  ) loss_i (
    .bit_clk_i(bit_clk_i),
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .loss_o   (loss)
  );

  // clock loss re-arms the hold-off: async assert, synchronized release
  assign hold_arst_n = rst_ni & ~loss;

  codec_pd_rst_sync #(.STAGES(SYNC_STAGES)) rsync_i (
    .clk_i  (bit_clk_i),
    .arst_ni(hold_arst_n),
    .rst_no (core_rst_n)
  );

  codec_pd_hold #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
    .clk_i (bit_clk_i),
    .rst_ni(core_rst_n),
    .hold_o(hold)
  );

  codec_pd_static_det #(.STATIC_CYCLES(STATIC_CYCLES)) stat_i (
    .clk_i     (bit_clk_i),
    .rst_ni    (core_rst_n),
    .ca_level_i(ca_level_i),
    .ctl_line_i(ctl_line_i),
    .static_o  (static_hi)
  );

  always_ff @(posedge bit_clk_i or negedge core_rst_n) begin
    if (!core_rst_n) pd_q <= 1'b1;
    else             pd_q <= hold | (a_mode_i == AM_PWRDN) | static_hi;
  end

  // loss bypasses pd_q: the bit clock that would load it is gone
  assign pd_o          = pd_q | loss;
  assign dout_hiz_o    = pd_o;
  assign reg_a_force_o = hold;
  assign reg_b_clr_o   = hold;
endmodule

// File: rtl/codec_pd_ctrl_chk.sv
`timescale 1ns/1ps
module codec_pd_ctrl_chk #(
  parameter int unsigned STATIC_CYCLES = 16
) (
  input logic       bit_clk_i,
  input logic       rst_ni,
  input logic [1:0] a_mode_i,
  input logic [1:0] ca_level_i,
  input logic       ctl_line_i,
  input logic       pd_o,
  input logic       reg_b_clr_o
);
  localparam int unsigned RW = $clog2(STATIC_CYCLES + 1);
  localparam logic [RW-1:0] RMAX = RW'(STATIC_CYCLES);

  logic [RW-1:0] run_q;
  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    run_q <= '0;
    else if (!(ctl_line_i && ca_level_i == 2'b00))  run_q <= '0;
    else if (run_q != RMAX)                         run_q <= run_q + 1'b1;
  end

  // R2
  strobe_implies_pd_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    reg_b_clr_o |-> pd_o);

  // R5
  mode_pd_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (a_mode_i == 2'b11) |=> pd_o);

  // R7
  static_run_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (run_q == RMAX) |=> pd_o);

  // R4
  pd_after_strobe_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    $fell(pd_o) |-> !$past(reg_b_clr_o));
endmodule

bind codec_pd_ctrl codec_pd_ctrl_chk #(.STATIC_CYCLES(STATIC_CYCLES)) chk_i (
  .bit_clk_i  (bit_clk_i),
  .rst_ni     (rst_ni),
  .a_mode_i   (a_mode_i),
  .ca_level_i (ca_level_i),
  .ctl_line_i (ctl_line_i),
  .pd_o       (pd_o),
  .reg_b_clr_o(reg_b_clr_o)
);

// File: tb/codec_pd_ctrl_tb_top.sv
`timescale 1ns/1ps
module codec_pd_ctrl_tb_top;
  localparam int unsigned HOLD = 25;
  localparam int unsigned STAT = 6;
  localparam int unsigned DIVL = 8;

  logic       bclk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk_run = 1'b1;
  logic [1:0] a_mode = 2'b00;
  logic [1:0] ca = 2'b01;
  logic       line = 1'b0;
  logic       pd, hiz, fa, fb;

  int errs = 0;
  int checks = 0;

  codec_pd_ctrl #(
    .HOLD_CYCLES  (HOLD),
    .STATIC_CYCLES(STAT),
    .DIV_LOG2     (DIVL)
  ) dut_i (
    .bit_clk_i    (bclk),
    .ref_clk_i    (ref_clk),
    .rst_ni       (rst_n),
    .a_mode_i     (a_mode),
    .ca_level_i   (ca),
    .ctl_line_i   (line),
    .pd_o         (pd),
    .dout_hiz_o   (hiz),
    .reg_a_force_o(fa),
    .reg_b_clr_o  (fb)
  );

  // 125 MHz bit clock; stops in the high state when bclk_run is 0
  initial forever begin
    #4;
    if (bclk_run) bclk = ~bclk;
    else          bclk = 1'b1;
  end

  initial begin
    #3;
    forever #500 ref_clk = ~ref_clk;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input bit ok, input longint act, input string exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%s", req, act, exp);
    end
  endtask

  task automatic chk_strobes(input string req, input logic exp);
    chk(req, fa, exp);
    chk(req, fb, exp);
  endtask

  initial begin
    #2000000;
    errs++;
    checks++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    longint t0, dt;
    int kf;

    // R1 reset state
    repeat (3) @(negedge bclk);
    chk("R1 pd", pd, 1'b1);
    chk("R1 hiz", hiz, 1'b1);
    chk_strobes("R1 strobes", 1'b1);
    rst_n = 1'b1;

    // R2 hold-off, edge by edge
    for (int k = 1; k <= HOLD + 10; k++) begin
      @(negedge bclk);
      chk_strobes("R2 strobes", (k < HOLD + 2));
      chk("R2 pd", pd, (k < HOLD + 3));
      chk("R10 hiz", hiz, pd);
    end

    // R5 R6 R9 register A mode codes
    for (int m = 0; m < 4; m++) begin
      a_mode = 2'(m);
      @(negedge bclk);
      chk((m == 3) ? "R5 pd" : "R6 pd", pd, (m == 3));
      chk("R10 hiz", hiz, pd);
      chk_strobes("R9 strobes", 1'b0);
      a_mode = 2'b00;
      @(negedge bclk);
      chk("R5 release", pd, 1'b0);
    end

    // R7 R8 static-high run lengths at the lowest address
    ca = 2'b00;
    for (int len = 1; len <= int'(STAT) + 3; len++) begin
      line = 1'b1;
      for (int k = 1; k <= len; k++) begin
        @(negedge bclk);
        chk((len <= int'(STAT)) ? "R8 short" : "R7 run", pd, (k >= int'(STAT) + 1));
        chk_strobes("R9 strobes", 1'b0);
      end
      line = 1'b0;
      @(negedge bclk);
      chk("R7 drop1", pd, (len >= int'(STAT)));
      @(negedge bclk);
      chk("R7 drop2", pd, 1'b0);
    end

    // R8 other address levels
    for (int c = 1; c < 4; c++) begin
      ca = 2'(c);
      line = 1'b1;
      for (int k = 1; k <= int'(STAT) + 3; k++) begin
        @(negedge bclk);
        chk("R8 addr", pd, 1'b0);
      end
      line = 1'b0;
      @(negedge bclk);
    end
    ca = 2'b01;

    // R3 clock stuck high
    @(negedge bclk);
    chk("R3 pre", pd, 1'b0);
    bclk_run = 1'b0;
    t0 = $time;
    while (!pd && ($time - t0) < 60000) #100;
    dt = $time - t0;
    chk_int("R3 window", (dt >= 10000) && (dt <= 40000), dt, "10000..40000 ns");
    chk("R3 hiz", hiz, 1'b1);
    chk_strobes("R3 strobes", 1'b1);
    #5000;
    chk("R3 held", pd, 1'b1);

    // R4 restart runs the hold-off again
    bclk_run = 1'b1;
    kf = 0;
    for (int k = 1; k <= 3000; k++) begin
      @(negedge bclk);
      if (!fb) begin
        kf = k;
        break;
      end
      chk("R4 pd high", pd, 1'b1);
    end
    chk_int("R4 edges", (kf >= int'(HOLD) + 2) && (kf < 2000), kf, ">= HOLD+2");
    chk("R4 pd lag", pd, 1'b1);
    chk("R4 fa", fa, 1'b0);
    @(negedge bclk);
    chk("R4 pd fall", pd, 1'b0);
    chk("R10 hiz", hiz, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule